// File: doc/BRIEF.md
# Split Decade Counter with Gated Clear and Preset-to-Nine

The block is a four-bit counter made of two sections that count on their own. A divide-by-two section drives output bit 0. A divide-by-five section drives output bits 3..1 as a binary value from 0 to 4. Each section has its own count input and advances on a falling edge of that input. Both count inputs are sampled by a free-running system clock through a two-stage synchronizer, and an edge detector picks out each high-to-low change.

The two sections can be chained in either direction. If bit 0 feeds the divide-by-five section, the counter runs in decimal (BCD) order. If bit 3 feeds the divide-by-two section, the counter runs in bi-quinary order, and bit 0 becomes a symmetric divide-by-ten square wave. The parameter `CHAIN` picks the wiring. It can chain the sections inside the block in either order, or leave both count inputs free so that the user wires them outside the block.

A clear gate has two inputs and acts only when both are high. A preset gate also has two inputs and acts only when both are high. Either gate overrides the output in the same cycle, without waiting for a clock edge, and loads its value into the counter state. If both gates are active, the preset wins.

Top module: `dsc_split_counter`

## Requirements
- R1: After a system reset (`rst_n` low), `q_o` reads 0.
- R2: With `CHAIN` set to external, each falling edge on `cnt0_i` inverts `q_o[0]` and leaves `q_o[3:1]` unchanged. Rising edges have no effect.
- R3: With `CHAIN` set to external, each falling edge on `cnt1_i` steps `q_o[3:1]` through 0,1,2,3,4 and back to 0, with `q_o[3]` as the MSB. `q_o[0]` is left unchanged.
- R4: While `clr_a_i` and `clr_b_i` are both high and the preset gate is inactive, `q_o` reads 0 in that same cycle. The counter stays at 0 after the gate is released. A single high clear input has no effect.
- R5: While `set_a_i` and `set_b_i` are both high, `q_o` reads 9 (4'b1001) in that same cycle. The counter stays at 9 after the gate is released. A single high preset input has no effect.
- R6: When the clear gate and the preset gate are active together, `q_o` reads 9.
- R7: Falling edges that occur while either gate is active are ignored. This includes an edge whose input is still low when the gate is released.
- R8: The count changes at the third rising edge of `clk` after a count input goes low. After two rising edges the output is still unchanged.
- R9: With `CHAIN` set to decimal, each falling edge on `cnt0_i` steps `q_o` through 0..9 and back to 0.
- R10: With `CHAIN` set to bi-quinary, each falling edge on `cnt1_i` steps `q_o` through 0,2,4,6,8,1,3,5,7,9 and then repeats.
- R11: In a chained setting, the count input that the internal link replaces has no effect on `q_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low system reset |
| cnt0_i | input | 1 | Count input of the divide-by-two section |
| cnt1_i | input | 1 | Count input of the divide-by-five section |
| clr_a_i | input | 1 | Clear gate input A |
| clr_b_i | input | 1 | Clear gate input B |
| set_a_i | input | 1 | Preset-to-nine gate input A |
| set_b_i | input | 1 | Preset-to-nine gate input B |
| q_o | output | 4 | Count: bit 0 from the divide-by-two section, bits 3..1 from the divide-by-five section |

## Verification
The hardest case to reach is a falling edge that lands inside a clear or preset window. The count input drops while the gate is active and is still low when the gate lifts. If the edge detector did not track its input during the override, it would report a late edge and count it. The stimulus drops the count input inside the window, releases the gate with the input still low, and waits several cycles before it checks that the count stayed at the forced value. It also walks the decimal counter to every state from 0 to 9 and applies a preset and a clear at each one.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        CHAIN_NONE = 2'd0,
        CHAIN_DEC  = 2'd1,
        CHAIN_BIQ  = 2'd2
    } chain_e;
endpackage

// File: rtl/dsc_fall_det.sv
module dsc_fall_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic fall_o
);
    // SYNC synchronizer stages plus one stage that holds the previous value
    logic [SYNC:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SYNC-1:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // an edge is seen when the previous value is 1 and the current value is 0
    assign fall_o = sh_q[SYNC] & ~sh_q[SYNC-1];
endmodule

// File: rtl/dsc_div2.sv
module dsc_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_i,
    input  logic adv_i,
    output logic q_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (set_i)      bit_d = 1'b1;
        else if (clr_i) bit_d = 1'b0;
        else if (adv_i) bit_d = ~bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign q_o = bit_q;
endmodule

// File: rtl/dsc_divn.sv
module dsc_divn #(
    parameter int MOD = 5,
    localparam int W = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         set_i,
    input  logic         adv_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (set_i)      cnt_d = TOP;
        else if (clr_i) cnt_d = '0;
        else if (adv_i) cnt_d = (cnt_q == TOP) ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;
endmodule

// File: rtl/dsc_split_counter.sv
module dsc_split_counter
    import dsc_pkg::*;
#(
    parameter chain_e CHAIN   = CHAIN_NONE,
    parameter int     SYNC    = 2,
    parameter int     HI_MOD  = 5,
    localparam int    HI_W    = $clog2(HI_MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt0_i,
    input  logic          cnt1_i,
    input  logic          clr_a_i,
    input  logic          clr_b_i,
    input  logic          set_a_i,
    input  logic          set_b_i,
    output logic [HI_W:0] q_o
);
    localparam logic [HI_W-1:0] HI_TOP = HI_W'(HI_MOD - 1);

    typedef struct packed {
        logic adv0;
        logic adv1;
    } adv_t;

    logic            clr_g, set_g, frc;
    logic            fall0, fall1;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;
    adv_t            adv_d;

    assign clr_g = clr_a_i & clr_b_i;
    assign set_g = set_a_i & set_b_i;
    assign frc   = clr_g | set_g;

    dsc_fall_det #(.SYNC(SYNC)) u_fd0 (
        .clk(clk), .rst_n(rst_n), .din_i(cnt0_i), .fall_o(fall0)
    );
    dsc_fall_det #(.SYNC(SYNC)) u_fd1 (
        .clk(clk), .rst_n(rst_n), .din_i(cnt1_i), .fall_o(fall1)
    );

    // the chained link is a falling edge of the feeding section's output, found from its state
    always_comb begin
        adv_d = '0;
        case (CHAIN)
            CHAIN_DEC: begin
                adv_d.adv0 = fall0;
                adv_d.adv1 = fall0 & lo_q;
            end
            CHAIN_BIQ: begin
                adv_d.adv1 = fall1;
                adv_d.adv0 = fall1 & (hi_q == HI_TOP);
            end
            default: begin
                adv_d.adv0 = fall0;
                adv_d.adv1 = fall1;
            end
        endcase
        if (frc) adv_d = '0;
    end

    dsc_div2 u_lo (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_g), .set_i(set_g),
        .adv_i(adv_d.adv0), .q_o(lo_q)
    );

    dsc_divn #(.MOD(HI_MOD)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_g), .set_i(set_g),
        .adv_i(adv_d.adv1), .q_o(hi_q)
    );

    // the gates override the output at once; the state loads at the next clock
    always_comb begin
        if (set_g)      q_o = {HI_TOP, 1'b1};
        else if (clr_g) q_o = '0;
        else            q_o = {hi_q, lo_q};
    end
endmodule

// File: rtl/dsc_split_counter_chk.sv
module dsc_split_counter_chk
    import dsc_pkg::*;
#(
    parameter chain_e CHAIN = CHAIN_NONE,
    parameter int     HI_W  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_g,
    input logic          set_g,
    input logic [HI_W:0] q_o
);
    logic frc;
    assign frc = clr_g | set_g;

    // R3: the upper field never leaves 0..4
    a_r3_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
        q_o[HI_W:1] <= HI_W'(4));

    // R3: without a gate, the upper field holds or steps by one, wrapping after 4
    a_r3_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc && !$past(frc)) |->
        ($stable(q_o[HI_W:1]) ||
         q_o[HI_W:1] == (($past(q_o[HI_W:1]) == HI_W'(4)) ? HI_W'(0)
                                                          : $past(q_o[HI_W:1]) + HI_W'(1))));

    // R4: clear without preset reads zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_g && !set_g) |-> (q_o == '0));

    // R5, R6: preset reads nine, even against clear
    a_r5_preset_nine: assert property (@(posedge clk) disable iff (!rst_n)
        set_g |-> (q_o == (HI_W+1)'(9)));

    // R7: when a gate releases, the forced value stays
    a_r7_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frc) |-> (q_o == $past(q_o)));

    generate
        if (CHAIN == CHAIN_DEC) begin : g_dec
            // R9: in decimal chaining, the upper field moves only when bit 0 falls
            a_r9_dec_carry: assert property (@(posedge clk) disable iff (!rst_n)
                (!frc && !$past(frc) && !$stable(q_o[HI_W:1])) |-> $fell(q_o[0]));
        end
        if (CHAIN == CHAIN_BIQ) begin : g_biq
            // R10: in bi-quinary chaining, bit 0 moves only when the upper field wraps
            a_r10_biq_carry: assert property (@(posedge clk) disable iff (!rst_n)
                (!frc && !$past(frc) && !$stable(q_o[0])) |-> (q_o[HI_W:1] == '0));
        end
    endgenerate
endmodule

bind dsc_split_counter dsc_split_counter_chk #(.CHAIN(CHAIN), .HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_g(clr_g), .set_g(set_g), .q_o(q_o)
);

// File: tb/dsc_split_counter_tb.sv
module dsc_split_counter_tb_top;
    import dsc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_a = 1'b0, clr_b = 1'b0, set_a = 1'b0, set_b = 1'b0;
    logic x0 = 1'b1, x1 = 1'b1, d0 = 1'b1, d1 = 1'b1, b0 = 1'b1, b1 = 1'b1;
    logic [3:0] qx, qd, qb;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsc_split_counter #(.CHAIN(CHAIN_NONE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt0_i(x0), .cnt1_i(x1),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b), .q_o(qx)
    );
    dsc_split_counter #(.CHAIN(CHAIN_DEC)) dut_dec_i (
        .clk(clk), .rst_n(rst_n), .cnt0_i(d0), .cnt1_i(d1),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b), .q_o(qd)
    );
    dsc_split_counter #(.CHAIN(CHAIN_BIQ)) dut_biq_i (
        .clk(clk), .rst_n(rst_n), .cnt0_i(b0), .cnt1_i(b1),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .set_a_i(set_a), .set_b_i(set_b), .q_o(qb)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // 0:x0 1:x1 2:d0 3:d1 4:b0 5:b1
    task automatic drive(input int sel, input logic v);
        case (sel)
            0: x0 = v;
            1: x1 = v;
            2: d0 = v;
            3: d1 = v;
            4: b0 = v;
            default: b1 = v;
        endcase
    endtask

    task automatic pulse(input int sel);
        drive(sel, 1'b0);
        idle(SETTLE);
        drive(sel, 1'b1);
        idle(SETTLE);
    endtask

    function automatic logic [3:0] biq_val(input int n);
        return 4'(((n % 10) % 5) * 2 + (n % 10) / 5);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] snap;
        int lo;
        int hi;
        idle(3);
        chk("R1 ext", qx, 4'd0);
        chk("R1 dec", qd, 4'd0);
        chk("R1 biq", qb, 4'd0);
        rst_n = 1'b1;
        idle(SETTLE);
        chk("R1 after release", qx, 4'd0);

        // R2: bit 0 toggles, upper field stays put
        lo = 0;
        for (int i = 0; i < 6; i++) begin
            drive(0, 1'b0);
            idle(SETTLE);
            lo ^= 1;
            chk("R2 toggle", qx, 4'(lo));
            drive(0, 1'b1);
            idle(SETTLE);
            chk("R2 rising ignored", qx, 4'(lo));
        end

        // R3: upper field counts modulo five
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            pulse(1);
            hi = (hi + 1) % 5;
            chk("R3 step", qx, 4'(hi * 2 + lo));
        end

        // R8: three-edge latency
        snap = qx;
        drive(0, 1'b0);
        idle(2);
        chk("R8 not yet", qx, snap);
        idle(1);
        lo ^= 1;
        chk("R8 updated", qx, 4'(hi * 2 + lo));
        drive(0, 1'b1);
        idle(SETTLE);

        // R4: single clear input ignored, gate clears at once and holds
        snap = qx;
        clr_a = 1'b1;
        idle(2);
        chk("R4 one input", qx, snap);
        clr_b = 1'b1;
        #1;
        chk("R4 immediate", qx, 4'd0);
        idle(2);
        clr_a = 1'b0;
        clr_b = 1'b0;
        idle(2);
        chk("R4 held", qx, 4'd0);

        // R5: single preset input ignored, gate presets to nine and holds
        set_b = 1'b1;
        idle(2);
        chk("R5 one input", qx, 4'd0);
        set_a = 1'b1;
        #1;
        chk("R5 immediate", qx, 4'd9);
        idle(2);
        set_a = 1'b0;
        set_b = 1'b0;
        idle(2);
        chk("R5 held", qx, 4'd9);
        pulse(0);
        chk("R5 counts on", qx, 4'd8);

        // R6: preset wins over clear
        clr_a = 1'b1; clr_b = 1'b1; set_a = 1'b1; set_b = 1'b1;
        #1;
        chk("R6 both", qx, 4'd9);
        idle(2);
        clr_a = 1'b0; clr_b = 1'b0; set_a = 1'b0; set_b = 1'b0;
        idle(2);
        chk("R6 after release", qx, 4'd9);

        // R7: an edge inside a clear window, with the input still low at release
        clr_a = 1'b1; clr_b = 1'b1;
        idle(2);
        drive(0, 1'b0);
        drive(1, 1'b0);
        idle(SETTLE);
        clr_a = 1'b0; clr_b = 1'b0;
        idle(SETTLE);
        chk("R7 ignored edge", qx, 4'd0);
        drive(0, 1'b1);
        drive(1, 1'b1);
        idle(SETTLE);
        chk("R7 after rise", qx, 4'd0);

        // R9: decimal sequence, with dec count restored to zero by the last clear
        for (int i = 1; i <= 25; i++) begin
            pulse(2);
            chk("R9 dec step", qd, 4'(i % 10));
        end

        // R10: bi-quinary sequence
        for (int i = 1; i <= 25; i++) begin
            pulse(5);
            chk("R10 biq step", qb, biq_val(i));
        end

        // R11: replaced inputs have no effect
        snap = qd;
        pulse(3);
        pulse(3);
        chk("R11 dec cnt1 ignored", qd, snap);
        snap = qb;
        pulse(4);
        pulse(4);
        chk("R11 biq cnt0 ignored", qb, snap);

        // R4 R5: preset and clear from every decimal state
        for (int s = 0; s < 10; s++) begin
            clr_a = 1'b1; clr_b = 1'b1;
            idle(2);
            clr_a = 1'b0; clr_b = 1'b0;
            idle(2);
            for (int k = 0; k < s; k++) pulse(2);
            chk("R9 reach state", qd, 4'(s));
            set_a = 1'b1; set_b = 1'b1;
            idle(2);
            set_a = 1'b0; set_b = 1'b0;
            idle(2);
            chk("R5 preset from state", qd, 4'd9);
            pulse(2);
            chk("R9 wrap after preset", qd, 4'd0);
            pulse(2);
            clr_a = 1'b1; clr_b = 1'b1;
            #1;
            chk("R4 clear from state", qd, 4'd0);
            idle(2);
            clr_a = 1'b0; clr_b = 1'b0;
            idle(2);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule